// File: doc/BRIEF.md
# Deep Standby Sequencer

This block decides when a microcontroller drops into its deepest software-entered low-power state and how it comes back. In normal running it keeps the oscillator and the distributed clock enabled. When the CPU issues its sleep strobe while the standby-select control bit is set, the block stops the oscillator and every clock and holds the DMA engine and on-chip peripherals in reset. CPU registers, RAM and port settings are left alone, so they keep their contents.

Three things bring the chip back. A qualified interrupt restarts the oscillator and waits a settling time chosen by a 3-bit code before clocks return and interrupt handling is started. A low reset pin restores clocks at once, and reset handling starts when the pin is released. A low hardware-standby pin overrides everything and parks the block in a separate hardware standby state. The settling time is counted in ticks of a free-running reference strobe, so the same block works whatever that tick rate is.

Top module: `pwrdn_ctrl`

## Requirements
- R1: From running, the block enters standby only on a cycle with `sleep_req`=1 and `stby_sel`=1; a sleep strobe with `stby_sel`=0 leaves it running with `osc_en`=1, `clk_en`=1, `periph_rst`=0.
- R2: In software standby `osc_en`=0, `clk_en`=0 and `periph_rst`=1; `periph_rst` is 1 whenever `clk_en` is 0. The reset value after `arst_n` is the running state.
- R3: In standby, `nmi`=1 wakes the block whatever `cpu_mask` is; `irq[i]` wakes it only when `irq_en[i]`=1 and `cpu_mask`=0. An unqualified request leaves all outputs unchanged.
- R4: On wake, `osc_en` goes to 1 on the next cycle with `clk_en` still 0; `clk_en` returns after N ticks of `ref_tick`, where code 0..5 gives N = 8192·2^code and codes 6 and 7 give 512 and 1024. With `ref_tick` high every cycle the block spends exactly N cycles with `osc_en`=1 and `clk_en`=0.
- R5: The settling code is captured on the wake cycle; later changes of `settle_sel` do not alter that countdown, and only cycles with `ref_tick`=1 advance it.
- R6: `irq_exc_start` is a one-cycle pulse in the first cycle that `clk_en` is 1 again after a settling countdown, and is 0 otherwise.
- R7: With `hwstby_n`=1, `res_n`=0 makes the next cycle show `osc_en`=1, `clk_en`=1, `periph_rst`=1 with no countdown, also during settling and over a same-cycle interrupt; the cycle after `res_n` returns to 1 shows the running state with a one-cycle `rst_exc_start` pulse.
- R8: `hwstby_n`=0 moves the block to hardware standby (`osc_en`=0, `clk_en`=0, `periph_rst`=1) on the next cycle from any state, ahead of reset and interrupts.
- R9: Hardware standby is left only when `hwstby_n`=1 while `res_n`=0, which leads into the reset path of R7; `hwstby_n`=1 with `res_n`=1 keeps it there, and interrupts have no effect in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous power-on reset of the block, active low |
| ref_tick | input | 1 | Free-running reference strobe that paces the settling count |
| sleep_req | input | 1 | Sleep instruction strobe from the CPU |
| stby_sel | input | 1 | Selects software standby on sleep |
| settle_sel | input | 3 | Oscillator settling time code |
| nmi | input | 1 | Non-maskable interrupt request |
| irq | input | N_IRQ | External interrupt requests |
| irq_en | input | N_IRQ | Per-request enable bits |
| cpu_mask | input | 1 | CPU interrupt mask flag |
| res_n | input | 1 | Reset pin, active low |
| hwstby_n | input | 1 | Hardware standby pin, active low |
| osc_en | output | 1 | Oscillator enable |
| clk_en | output | 1 | System clock gate enable |
| periph_rst | output | 1 | Reset to DMA engine and on-chip peripherals |
| irq_exc_start | output | 1 | Pulse starting interrupt exception handling |
| rst_exc_start | output | 1 | Pulse starting reset exception handling |

## Verification
A wrong state register shows up at the three level outputs on the very next cycle, since each state has a distinct pattern of oscillator, clock and peripheral reset, except software and hardware standby which share one; those two are told apart by driving an interrupt and watching whether the oscillator restarts one cycle later. A settling counter that loads the wrong limit, misses ticks or ignores the capture shows only at the end of the countdown, as a clock return that is early or late by a counted number of cycles, so the measured window length is compared against the exact value for each code tried. Priority mistakes among hardware standby, reset and interrupt appear one cycle after the collision as the wrong output pattern.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

    localparam int SEL_W   = 3;
    localparam int N_CODES = 1 << SEL_W;

    typedef enum logic [2:0] {
        PD_RUN      = 3'd0,
        PD_STANDBY  = 3'd1,
        PD_SETTLE   = 3'd2,
        PD_RST_HOLD = 3'd3,
        PD_HW_STBY  = 3'd4
    } pd_state_t;

    typedef struct packed {
        pd_state_t st;
        logic      iexc;
        logic      rexc;
    } pd_fsm_t;

endpackage

// File: rtl/pwrdn_wake_qual.sv
module pwrdn_wake_qual #(
    parameter int N_IRQ = 3
) (
    input  logic             nmi,
    input  logic [N_IRQ-1:0] irq,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             cpu_mask,
    output logic             wake
);
    logic [N_IRQ-1:0] qual;

    // Each request line is gated by its own enable and the CPU mask.
    for (genvar g = 0; g < N_IRQ; g++) begin : g_line
        assign qual[g] = irq[g] & irq_en[g] & ~cpu_mask;
    end

    // NMI is never masked.
    assign wake = nmi | (|qual);

endmodule

// File: rtl/pwrdn_settle_timer.sv
module pwrdn_settle_timer
    import pwrdn_pkg::*;
#(
    parameter int BASE_LOG2  = 13,
    parameter int SHORT_LOG2 = 9
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             start,
    input  logic             run,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             done
);
    localparam int LONG_CODES = 6;
    localparam int LIM_W      = BASE_LOG2 + LONG_CODES - 1;

    typedef struct packed {
        logic [LIM_W-1:0] cnt;
        logic [LIM_W-1:0] lim;
    } tmr_t;

    logic [LIM_W-1:0] lim_tab [N_CODES];
    tmr_t             tmr_d, tmr_q;

    // Terminal value minus one for each code: long range doubles from the base,
    // the two top codes select the short range.
    for (genvar g = 0; g < N_CODES; g++) begin : g_lim
        if (g < LONG_CODES) begin : g_long
            assign lim_tab[g] = LIM_W'((64'd1 << (BASE_LOG2 + g)) - 64'd1);
        end else begin : g_short
            assign lim_tab[g] = LIM_W'((64'd1 << (SHORT_LOG2 + g - LONG_CODES)) - 64'd1);
        end
    end

    assign done = run & tick & (tmr_q.cnt == tmr_q.lim);

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.cnt = '0;
            tmr_d.lim = lim_tab[sel];
        end else if (run && tick && !done) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
    import pwrdn_pkg::*;
#(
    parameter int N_IRQ      = 3,
    parameter int BASE_LOG2  = 13,
    parameter int SHORT_LOG2 = 9
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             ref_tick,
    input  logic             sleep_req,
    input  logic             stby_sel,
    input  logic [SEL_W-1:0] settle_sel,
    input  logic             nmi,
    input  logic [N_IRQ-1:0] irq,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             cpu_mask,
    input  logic             res_n,
    input  logic             hwstby_n,
    output logic             osc_en,
    output logic             clk_en,
    output logic             periph_rst,
    output logic             irq_exc_start,
    output logic             rst_exc_start
);
    pd_fsm_t   fsm_d, fsm_q;
    pd_state_t state_q;
    logic      wake;
    logic      settle_done;
    logic      settle_start;
    logic      settle_run;

    assign state_q = fsm_q.st;

    pwrdn_wake_qual #(.N_IRQ(N_IRQ)) u_wake (
        .nmi      (nmi),
        .irq      (irq),
        .irq_en   (irq_en),
        .cpu_mask (cpu_mask),
        .wake     (wake)
    );

    assign settle_start = (fsm_q.st == PD_STANDBY) && (fsm_d.st == PD_SETTLE);
    assign settle_run   = (fsm_q.st == PD_SETTLE);

    pwrdn_settle_timer #(
        .BASE_LOG2  (BASE_LOG2),
        .SHORT_LOG2 (SHORT_LOG2)
    ) u_timer (
        .clk    (clk),
        .arst_n (arst_n),
        .start  (settle_start),
        .run    (settle_run),
        .tick   (ref_tick),
        .sel    (settle_sel),
        .done   (settle_done)
    );

    // Priority: hardware standby pin, then reset pin, then normal sequencing.
    always_comb begin
        fsm_d      = fsm_q;
        fsm_d.iexc = 1'b0;
        fsm_d.rexc = 1'b0;
        if (!hwstby_n) begin
            fsm_d.st = PD_HW_STBY;
        end else if (fsm_q.st == PD_HW_STBY) begin
            if (!res_n) begin
                fsm_d.st = PD_RST_HOLD;
            end
        end else if (!res_n) begin
            fsm_d.st = PD_RST_HOLD;
        end else begin
            unique case (fsm_q.st)
                PD_RUN: begin
                    if (sleep_req && stby_sel) begin
                        fsm_d.st = PD_STANDBY;
                    end
                end
                PD_STANDBY: begin
                    if (wake) begin
                        fsm_d.st = PD_SETTLE;
                    end
                end
                PD_SETTLE: begin
                    if (settle_done) begin
                        fsm_d.st   = PD_RUN;
                        fsm_d.iexc = 1'b1;
                    end
                end
                PD_RST_HOLD: begin
                    fsm_d.st   = PD_RUN;
                    fsm_d.rexc = 1'b1;
                end
                default: begin
                    fsm_d.st = PD_RUN;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            fsm_q <= '{st: PD_RUN, iexc: 1'b0, rexc: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    always_comb begin
        unique case (fsm_q.st)
            PD_RUN:      {osc_en, clk_en, periph_rst} = 3'b110;
            PD_SETTLE:   {osc_en, clk_en, periph_rst} = 3'b101;
            PD_RST_HOLD: {osc_en, clk_en, periph_rst} = 3'b111;
            default:     {osc_en, clk_en, periph_rst} = 3'b001;
        endcase
    end

    assign irq_exc_start = fsm_q.iexc;
    assign rst_exc_start = fsm_q.rexc;

endmodule

// File: rtl/pwrdn_ctrl_chk.sv
module pwrdn_ctrl_chk
    import pwrdn_pkg::*;
(
    input logic      clk,
    input logic      arst_n,
    input logic      sleep_req,
    input logic      stby_sel,
    input logic      res_n,
    input logic      hwstby_n,
    input logic      osc_en,
    input logic      clk_en,
    input logic      periph_rst,
    input logic      irq_exc_start,
    input logic      rst_exc_start,
    input pd_state_t st
);

    assert_sleep_without_select_R1: assert property (@(posedge clk) disable iff (!arst_n)
        (st == PD_RUN && sleep_req && !stby_sel && res_n && hwstby_n) |=> (clk_en && !periph_rst));

    assert_gated_in_reset_R2: assert property (@(posedge clk) disable iff (!arst_n)
        !clk_en |-> periph_rst);

    assert_standby_osc_off_R2: assert property (@(posedge clk) disable iff (!arst_n)
        (st == PD_STANDBY) |-> (!osc_en && !clk_en));

    assert_irq_start_after_settle_R6: assert property (@(posedge clk) disable iff (!arst_n)
        irq_exc_start |-> (clk_en && $past(st == PD_SETTLE)));

    assert_irq_start_single_R6: assert property (@(posedge clk) disable iff (!arst_n)
        irq_exc_start |=> !irq_exc_start);

    assert_reset_clocks_now_R7: assert property (@(posedge clk) disable iff (!arst_n)
        (hwstby_n && !res_n && st != PD_HW_STBY) |=> (osc_en && clk_en && periph_rst));

    assert_reset_start_origin_R7: assert property (@(posedge clk) disable iff (!arst_n)
        rst_exc_start |-> ($past(st == PD_RST_HOLD) && clk_en && !periph_rst));

    assert_hw_pin_override_R8: assert property (@(posedge clk) disable iff (!arst_n)
        !hwstby_n |=> (!osc_en && !clk_en && periph_rst));

    assert_hw_exit_needs_reset_R9: assert property (@(posedge clk) disable iff (!arst_n)
        (st == PD_HW_STBY && hwstby_n && res_n) |=> (st == PD_HW_STBY && !osc_en));

endmodule

bind pwrdn_ctrl pwrdn_ctrl_chk u_chk (
    .clk           (clk),
    .arst_n        (arst_n),
    .sleep_req     (sleep_req),
    .stby_sel      (stby_sel),
    .res_n         (res_n),
    .hwstby_n      (hwstby_n),
    .osc_en        (osc_en),
    .clk_en        (clk_en),
    .periph_rst    (periph_rst),
    .irq_exc_start (irq_exc_start),
    .rst_exc_start (rst_exc_start),
    .st            (state_q)
);

// File: tb/test_pwrdn_ctrl.sv
module test_pwrdn_ctrl;

    logic       clk = 1'b0;
    logic       arst_n = 1'b0;
    logic       ref_tick = 1'b1;
    logic       sleep_req = 1'b0;
    logic       stby_sel = 1'b0;
    logic [2:0] settle_sel = 3'd7;
    logic       nmi = 1'b0;
    logic [2:0] irq = '0;
    logic [2:0] irq_en = '0;
    logic       cpu_mask = 1'b0;
    logic       res_n = 1'b1;
    logic       hwstby_n = 1'b1;
    logic       osc_en, clk_en, periph_rst, irq_exc_start, rst_exc_start;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    pwrdn_ctrl i_pwrdn_ctrl (
        .clk           (clk),
        .arst_n        (arst_n),
        .ref_tick      (ref_tick),
        .sleep_req     (sleep_req),
        .stby_sel      (stby_sel),
        .settle_sel    (settle_sel),
        .nmi           (nmi),
        .irq           (irq),
        .irq_en        (irq_en),
        .cpu_mask      (cpu_mask),
        .res_n         (res_n),
        .hwstby_n      (hwstby_n),
        .osc_en        (osc_en),
        .clk_en        (clk_en),
        .periph_rst    (periph_rst),
        .irq_exc_start (irq_exc_start),
        .rst_exc_start (rst_exc_start)
    );

    // Row: sleep, sel, nmi, irq[2:0], en[2:0], mask, res_n, hw_n | osc, clk, prst, iexc, rexc
    localparam int NV = 19;
    localparam logic [16:0] VEC [NV] = '{
        17'b0_0_0_000_000_0_1_1_11000, // R2 idle run
        17'b1_0_0_000_000_0_1_1_11000, // R1 sleep without select
        17'b1_1_0_000_000_0_1_1_00100, // R1 R2 enter standby
        17'b0_0_0_001_000_0_1_1_00100, // R3 irq0 disabled
        17'b0_0_0_010_010_1_1_1_00100, // R3 irq1 masked
        17'b0_0_0_100_011_0_1_1_00100, // R3 irq2 not enabled
        17'b0_0_0_000_000_0_0_1_11100, // R7 reset pin low: clocks at once
        17'b0_0_0_000_000_0_0_1_11100, // R7 held
        17'b0_0_0_000_000_0_1_1_11001, // R7 release: reset handling pulse
        17'b0_0_0_000_000_0_1_1_11000, // R7 pulse is one cycle
        17'b1_1_0_000_000_0_1_1_00100, // R1 standby again
        17'b0_0_1_000_000_0_0_0_00100, // R8 hw pin beats reset and nmi
        17'b0_0_1_000_000_0_1_0_00100, // R8 stays
        17'b0_0_1_111_111_0_1_1_00100, // R9 hw pin high, reset high: no exit, interrupts ignored
        17'b0_0_0_000_000_0_0_1_11100, // R9 hw pin high with reset low
        17'b0_0_0_000_000_0_1_1_11001, // R9 reset path exit
        17'b1_1_0_000_000_0_1_1_00100, // R1 standby
        17'b0_0_1_000_000_0_0_1_11100, // R7 reset beats same-cycle nmi
        17'b0_0_0_000_000_0_1_1_11001  // R7 release
    };
    localparam int VREQ [NV] = '{2,1,1,3,3,3,7,7,7,7,1,8,8,9,9,9,1,7,7};

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: outputs %b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] outs();
        return {osc_en, clk_en, periph_rst, irq_exc_start, rst_exc_start};
    endfunction

    task automatic idle();
        sleep_req = 0; stby_sel = 0; nmi = 0; irq = '0; irq_en = '0;
        cpu_mask = 0; res_n = 1; hwstby_n = 1; ref_tick = 1;
    endtask

    task automatic enter_standby();
        sleep_req = 1; stby_sel = 1;
        step();
        sleep_req = 0; stby_sel = 0;
    endtask

    // Wake from standby and measure the oscillator-on, clock-off window.
    task automatic settle_run(input string tag, input int exp_n, input logic [2:0] sel,
                              input logic use_nmi, input logic half_rate, input logic mask);
        int n = 0;
        enter_standby();
        check({tag, " standby"}, outs(), 5'b00100);
        settle_sel = sel;
        cpu_mask   = mask;
        if (use_nmi) nmi = 1;
        else begin irq = 3'b010; irq_en = 3'b010; end
        step();
        nmi = 0; irq = '0; irq_en = '0; cpu_mask = 0;
        for (int i = 0; i < 20000; i++) begin
            if (!(osc_en && !clk_en)) break;
            n++;
            if (i == 3) settle_sel = 3'd0;  // R5 change after capture
            ref_tick = half_rate ? i[0] : 1'b1;
            step();
        end
        ref_tick = 1;
        n_chk++;
        if (n != exp_n) begin
            n_bad++;
            $display("FAIL %s: settle window %0d expected %0d", tag, n, exp_n);
        end
        check({tag, " R6 first clocked cycle"}, outs(), 5'b11010);
        step();
        check({tag, " R6 pulse ends"}, outs(), 5'b11000);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        check("R2 reset state", outs(), 5'b11000);
        arst_n = 1;
        step();
        check("R2 running after reset", outs(), 5'b11000);

        for (int v = 0; v < NV; v++) begin
            {sleep_req, stby_sel, nmi, irq, irq_en, cpu_mask, res_n, hwstby_n} = VEC[v][16:5];
            step();
            check($sformatf("vector %0d R%0d", v, VREQ[v]), outs(), VEC[v][4:0]);
        end
        idle();
        step();

        // R4 code 7 via NMI, also with the CPU mask set (R3).
        settle_run("R4 code7 nmi R3 masked", 1024, 3'd7, 1'b1, 1'b0, 1'b1);
        // R4 code 6 via an enabled IRQ; R5 select changed mid-count.
        settle_run("R4 R5 code6 irq1", 512, 3'd6, 1'b0, 1'b0, 1'b0);
        // R5 tick gating: every other cycle doubles the window.
        settle_run("R5 half-rate tick", 1024, 3'd6, 1'b0, 1'b1, 1'b0);
        // R4 longest code tried: code 0.
        settle_run("R4 code0", 8192, 3'd0, 1'b1, 1'b0, 1'b0);

        // R7 reset pin during settling: clocks at once, no interrupt pulse.
        enter_standby();
        settle_sel = 3'd7;
        nmi = 1;
        step();
        nmi = 0;
        check("R4 oscillator on after wake", outs(), 5'b10100);
        repeat (5) step();
        res_n = 0;
        step();
        check("R7 reset during settle", outs(), 5'b11100);
        res_n = 1;
        step();
        check("R7 release after settle abort", outs(), 5'b11001);
        step();
        check("R7 back to run", outs(), 5'b11000);

        // R8 hardware standby from run, then R9 exit.
        hwstby_n = 0;
        step();
        check("R8 hw standby from run", outs(), 5'b00100);
        hwstby_n = 1; res_n = 0;
        step();
        check("R9 exit into reset hold", outs(), 5'b11100);
        res_n = 1;
        step();
        check("R9 reset handling after hw standby", outs(), 5'b11001);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule